// File: doc/BRIEF.md
# Double-Pumped Shared RAM Arbiter

This block lets a processor and a video fetch engine share one single-port RAM without either of them ever waiting. The RAM and its steering logic run on a clock at twice the system rate, and both clocks come from one source, so every system cycle holds exactly two fast cycles. The fast cycle whose rising edge coincides with a system edge belongs to the processor. The fast cycle in the middle of the system period belongs to the video side. A flop that toggles in the fast domain tracks which slot is current. The system clock never feeds logic. The toggle is held clear until a reset-release signal, registered on the system clock, lets it run. This fixes its alignment to the system edges.

Each client presents one request per system cycle, sampled on a system edge. Its read data and read-valid come straight from a per-client register, and are ready to be sampled on the following system edge. Neither port has a ready signal. The arbiter accepts every request in the cycle it is presented, so no client is ever back-pressured. A valid qualifier marks a request, and a registered read-valid marks returned data. A write from the processor lands in the RAM in the processor slot. A video read of the same word in the same system cycle therefore sees the new value.

Top module: `dual_slot_ram`

## Requirements
- R1: While `rst_n` is low, and on every system cycle after its release until a request is served, `cpu_rvalid` and `vid_rvalid` are 0 and both read-data outputs are 0.
- R2: The slot toggle is held in the video state until the system-domain release register is set. From then on it alternates on every fast edge, so the processor slot is the fast edge that coincides with a system edge.
- R3: A processor request with `cpu_valid`=1 and `cpu_we`=1 writes `cpu_wdata` to `cpu_addr` in the processor slot. A video read of the same address presented in the same system cycle returns the newly written value.
- R4: A processor request with `cpu_valid`=1 and `cpu_we`=0 returns the stored word on `cpu_rdata` with `cpu_rvalid`=1, both ready on the next system edge. A write request gives `cpu_rvalid`=0 on that edge.
- R5: A video request with `vid_valid`=1 returns the word at `vid_addr` on `vid_rdata` with `vid_rvalid`=1 on the next system edge. These outputs change only in the video slot, so they still show the previous result during the first half of the system cycle.
- R6: Video requests never modify RAM contents.
- R7: When a client presents no read, its read-valid is 0 on the next system edge, and its read-data output keeps the last value it returned.
- R8: Pulsing `rst_n` low mid-operation re-establishes slot alignment after release. RAM contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock |
| clk_2x | input | 1 | RAM clock, twice clk_sys, edge-aligned |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | Processor request is a write |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Processor write data |
| cpu_rvalid | output | 1 | Processor read data valid |
| cpu_rdata | output | DW | Processor read data (registered) |
| vid_valid | input | 1 | Video read request present |
| vid_addr | input | AW | Video word address |
| vid_rvalid | output | 1 | Video read data valid |
| vid_rdata | output | DW | Video read data (registered) |

## Verification
The two functions that share a system cycle are a processor write and a video read. When both target the same word, the order of the two slots decides what the video side sees. The bench sweeps every pairing of processor write address with video read address over the 16-word configuration, so the two addresses coincide 16 times and differ in all other pairings. Each video result is judged against a model that applies the write before the read whenever the addresses match. Each result is also sampled early in the next cycle, to confirm that the video outputs have not yet moved before the mid-cycle slot.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic {
    SLOT_VID = 1'b0,
    SLOT_CPU = 1'b1
  } slot_e;
endpackage

// File: rtl/dsr_run_sync.sv
module dsr_run_sync (
  input  logic clk_sys,
  input  logic rst_n,
  output logic run
);
  logic stage_q;

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      run     <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      run     <= stage_q;
    end
  end
endmodule

// File: rtl/dsr_phase.sv
module dsr_phase
  import dsr_pkg::*;
(
  input  logic  clk_2x,
  input  logic  run,
  output slot_e slot
);
  // Held in the video state until run rises on a system edge; the fast edge
  // coinciding with that system edge still sees run low, so the first
  // toggle lands mid-cycle and every later processor slot lines up with clk_sys.
  always_ff @(posedge clk_2x) begin
    if (!run) slot <= SLOT_VID;
    else      slot <= (slot == SLOT_CPU) ? SLOT_VID : SLOT_CPU;
  end
endmodule

// File: rtl/dsr_ram.sv
module dsr_ram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/dual_slot_ram.sv
module dual_slot_ram
  import dsr_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_sys,
  input  logic          clk_2x,
  input  logic          rst_n,
  input  logic          cpu_valid,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_rvalid,
  output logic [DW-1:0] cpu_rdata,
  input  logic          vid_valid,
  input  logic [AW-1:0] vid_addr,
  output logic          vid_rvalid,
  output logic [DW-1:0] vid_rdata
);
  logic          run;
  slot_e         slot;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_rdata;
  logic          vid_pend_q;
  logic [AW-1:0] vid_addr_q;
  logic          cpu_rd;

  dsr_run_sync u_run (
    .clk_sys (clk_sys),
    .rst_n   (rst_n),
    .run     (run)
  );

  dsr_phase u_phase (
    .clk_2x (clk_2x),
    .run    (run),
    .slot   (slot)
  );

  // Processor slot uses the port directly (sampled on the shared edge);
  // the video slot uses the copy latched in that same edge.
  assign ram_addr = (slot == SLOT_CPU) ? cpu_addr : vid_addr_q;
  assign ram_we   = run && (slot == SLOT_CPU) && cpu_valid && cpu_we;
  assign cpu_rd   = cpu_valid && !cpu_we;

  dsr_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk_2x),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (cpu_wdata),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk_2x) begin
    if (!run) begin
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
      vid_rvalid <= 1'b0;
      vid_rdata  <= '0;
      vid_pend_q <= 1'b0;
      vid_addr_q <= '0;
    end else if (slot == SLOT_CPU) begin
      cpu_rvalid <= cpu_rd;
      if (cpu_rd) cpu_rdata <= ram_rdata;
      vid_pend_q <= vid_valid;
      vid_addr_q <= vid_addr;
    end else begin
      vid_rvalid <= vid_pend_q;
      if (vid_pend_q) vid_rdata <= ram_rdata;
    end
  end
endmodule

// File: rtl/dsr_checks.sv
module dsr_checks #(
  parameter int DW = 8
) (
  input logic          clk_sys,
  input logic          clk_2x,
  input logic          rst_n,
  input logic          run,
  input logic          slot_bit,
  input logic          ram_we,
  input logic          vid_valid,
  input logic          cpu_rvalid,
  input logic [DW-1:0] cpu_rdata,
  input logic          vid_rvalid,
  input logic [DW-1:0] vid_rdata
);
  a_r2_toggles: assert property (@(posedge clk_2x) disable iff (!rst_n)
    run |=> (slot_bit != $past(slot_bit)));

  a_r2_held_idle: assert property (@(posedge clk_2x) disable iff (!rst_n)
    !run |=> !slot_bit);

  a_r2_aligned_to_sys: assert property (@(posedge clk_sys) disable iff (!rst_n)
    run |-> slot_bit);

  a_r6_write_only_cpu_slot: assert property (@(posedge clk_2x) disable iff (!rst_n)
    ram_we |-> (slot_bit && run));

  a_r5_vid_stable_in_cpu_slot: assert property (@(posedge clk_2x) disable iff (!rst_n)
    (run && slot_bit) |=> ($stable(vid_rdata) && $stable(vid_rvalid)));

  a_r4_cpu_stable_in_vid_slot: assert property (@(posedge clk_2x) disable iff (!rst_n)
    (run && !slot_bit) |=> ($stable(cpu_rdata) && $stable(cpu_rvalid)));

  a_r1_quiet_before_run: assert property (@(posedge clk_2x) disable iff (!rst_n)
    !run |=> (!cpu_rvalid && !vid_rvalid));

  a_r7_no_req_no_valid: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (run && !vid_valid) |=> !vid_rvalid);
endmodule

bind dual_slot_ram dsr_checks #(.DW(DW)) u_chk (
  .clk_sys    (clk_sys),
  .clk_2x     (clk_2x),
  .rst_n      (rst_n),
  .run        (run),
  .slot_bit   (slot),
  .ram_we     (ram_we),
  .vid_valid  (vid_valid),
  .cpu_rvalid (cpu_rvalid),
  .cpu_rdata  (cpu_rdata),
  .vid_rvalid (vid_rvalid),
  .vid_rdata  (vid_rdata)
);

// File: tb/dual_slot_ram_tb_top.sv
`timescale 1ns/100ps
module dual_slot_ram_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk_sys = 1'b0;
  logic clk_2x  = 1'b0;
  logic rst_n   = 1'b0;
  logic          cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_rvalid;
  logic [DW-1:0] cpu_rdata;
  logic          vid_valid = 1'b0;
  logic [AW-1:0] vid_addr = '0;
  logic          vid_rvalid;
  logic [DW-1:0] vid_rdata;

  int n_vec = 0;
  int n_bad = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] vid_prev;
  logic          vid_prev_v;

  // clk_sys toggles on every clk_2x rising edge: 10 ns system period (100 MHz)
  initial forever begin
    #2.5 clk_2x = ~clk_2x;
    if (clk_2x) clk_sys = ~clk_sys;
  end

  dual_slot_ram #(.AW(AW), .DW(DW)) dut_i (
    .clk_sys(clk_sys), .clk_2x(clk_2x), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .vid_valid(vid_valid), .vid_addr(vid_addr),
    .vid_rvalid(vid_rvalid), .vid_rdata(vid_rdata)
  );

  task automatic check(input string req, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // Drive a request now, then wait for the system edge that samples it.
  // At edge+2 the video outputs must still show the prior result (R5);
  // at edge+7 both clients' results for this request are checked.
  task automatic cycle(input logic cv, input logic cw, input int ca, input int cd,
                       input logic vv, input int va, input logic chk);
    logic [DW-1:0] exp_v, exp_c, old_c;
    cpu_valid = cv; cpu_we = cw; cpu_addr = AW'(ca); cpu_wdata = DW'(cd);
    vid_valid = vv; vid_addr = AW'(va);
    old_c = cpu_rdata;
    exp_c = model[ca];
    if (cv && cw) model[ca] = DW'(cd);
    exp_v = model[va];
    vid_prev = vid_rdata; vid_prev_v = vid_rvalid;
    @(posedge clk_sys);
    #2;
    if (chk) begin
      check("R5 early hold", vid_rdata, vid_prev);
      check("R5 early hold valid", vid_rvalid, vid_prev_v);
    end
    #5;
    if (!chk) return;
    if (cv && !cw) begin
      check("R4 cpu rvalid", cpu_rvalid, 1);
      check("R4 cpu rdata", cpu_rdata, exp_c);
    end else begin
      check("R7 cpu rvalid idle", cpu_rvalid, 0);
      check("R7 cpu rdata hold", cpu_rdata, old_c);
    end
    if (vv) begin
      check("R5 vid rvalid", vid_rvalid, 1);
      check((cv && cw && ca == va) ? "R3 write then video read" : "R5 vid rdata",
            vid_rdata, exp_v);
    end else begin
      check("R7 vid rvalid idle", vid_rvalid, 0);
      check("R7 vid rdata hold", vid_rdata, vid_prev);
    end
  endtask

  task automatic do_reset();
    cpu_valid = 0; vid_valid = 0;
    rst_n = 0;
    repeat (3) @(posedge clk_sys);
    #7;
    check("R1 cpu rvalid in reset", cpu_rvalid, 0);
    check("R1 vid rvalid in reset", vid_rvalid, 0);
    check("R1 cpu rdata in reset", cpu_rdata, 0);
    check("R1 vid rdata in reset", vid_rdata, 0);
    rst_n = 1;
    repeat (4) begin
      @(posedge clk_sys);
      #7;
      check("R1 cpu rvalid after release", cpu_rvalid, 0);
      check("R1 vid rvalid after release", vid_rvalid, 0);
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    do_reset();
    // fill: R3 writes through the processor slot
    for (int a = 0; a < DEPTH; a++)
      cycle(1, 1, a, (a * 37 + 5) & 8'hFF, 0, 0, 0);
    // processor reads alone, R4
    for (int a = 0; a < DEPTH; a++)
      cycle(1, 0, a, 0, 0, 0, 1);
    // R3 / R6: every write address against every video read address
    for (int i = 0; i < DEPTH; i++)
      for (int j = 0; j < DEPTH; j++)
        cycle(1, 1, i, ((i * 16 + j) ^ 8'h5A) & 8'hFF, 1, j, 1);
    // concurrent reads on both clients, R4 / R5
    for (int i = 0; i < DEPTH; i++)
      for (int j = 0; j < DEPTH; j++)
        cycle(1, 0, i, 0, 1, (j + i) % DEPTH, 1);
    // idle cycles and alternating patterns, R7
    cycle(0, 0, 0, 0, 0, 0, 1);
    cycle(1, 0, 3, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 1, 9, 1);
    cycle(0, 0, 0, 0, 0, 0, 1);
    // R6: video-only reads leave memory intact, verified by processor reads
    for (int a = 0; a < DEPTH; a++) cycle(0, 0, 0, 0, 1, a, 1);
    for (int a = 0; a < DEPTH; a++) cycle(1, 0, a, 0, 0, 0, 1);
    // R8: mid-run reset, realignment and preserved contents
    do_reset();
    for (int a = 0; a < DEPTH; a++)
      cycle(1, 1, a, (a * 11 + 1) & 8'hFF, 1, a, 1);
    for (int a = 0; a < DEPTH; a++)
      cycle(1, 0, a, 0, 1, DEPTH - 1 - a, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule